// File: doc/BRIEF.md
# Serial Bus Activity Watchdog

This block is a watchdog timer that needs no dedicated service input. It watches the clock and data wires of a two-wire serial bus without driving them. Each time a properly framed transfer ends, it restarts its countdown. A host that is still running therefore keeps the watchdog quiet just by talking on the bus, to any target. If the bus stays silent for longer than the selected period, the block sends a one-cycle timeout pulse to the reset sequencer.

Both bus wires first pass through a two-flop synchroniser. A small frame tracker then looks for start and stop conditions. The smallest transfer that counts is:
1. a start condition,
2. one clock low phase,
3. one clock high phase,
4. a stop condition.

A two-bit period register picks one of three timeout lengths or turns the watchdog off. A write-protect input freezes that register.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst_n` is low, the period register returns to code 00 and `timeout_o` stays low. The count is held at zero.
- R2: The period codes are 00 = TICKS_LONG, 01 = TICKS_MED and 10 = TICKS_SHORT. With one of these codes and no qualifying bus frame, `timeout_o` goes high for exactly one cycle after TICKS clock edges from reset release. It then pulses again every TICKS edges.
- R3: Period code 11 turns the watchdog off. `timeout_o` stays low for as long as the code stays 11.
- R4: When `wp_i` is low, a cycle with `per_we_i` high loads `per_wdata_i` into the period register. The new value appears on `per_sel_o` after the next clock edge.
- R5: When `wp_i` is high, `per_we_i` has no effect and `per_sel_o` keeps its value.
- R6: A qualifying frame restarts the count, and the next pulse comes TICKS + 3 edges after the stop appears on the pins. The frame is: SDA falls while SCL is high (start), then SCL goes low, then SCL goes high, then SDA rises while SCL is high (stop). Each phase of the frame may last as little as two clock cycles.
- R7: A start with clock phases but no stop does not restart the count.
- R8: A start followed directly by a stop, with no SCL low phase in between, does not restart the count.
- R9: A full transfer with nine clocked bits between the start and the stop restarts the count, with the same timing as in R6.
- R10: Asserting `rst_n` low in the middle of a count restarts it. The next pulse comes TICKS edges after release.
- R11: If the period is shortened while the count already exceeds the new limit, the pulse fires on the edge right after the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Observed bus clock wire (asynchronous) |
| sda_i | input | 1 | Observed bus data wire (asynchronous) |
| wp_i | input | 1 | Write protect; high freezes the period register |
| per_we_i | input | 1 | Period register write strobe |
| per_wdata_i | input | 2 | Period code to write |
| per_sel_o | output | 2 | Current period code |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The checks assume that the three TICKS values are at least two, so an expiry pulse can never be followed directly by another. They also assume the period register is the only source of the period code. The bus checks assume that SDA only changes while SCL is low, except for the deliberate start and stop edges. They further assume that every wire level is held for at least two sampling cycles, so no phase is lost in the synchroniser. The stimulus drives every wire at the falling clock edge, holds each phase for two or more cycles and changes only one wire per step. The bench also returns both wires high together with reset, so that no stray edge appears.

// File: rtl/bwd_pkg.sv
// Shared types for the bus activity watchdog.
// Assumes: period codes are decoded only by the timer and held in the top.
package bwd_pkg;
    typedef enum logic [1:0] {
        PER_LONG  = 2'b00,
        PER_MED   = 2'b01,
        PER_SHORT = 2'b10,
        PER_OFF   = 2'b11
    } per_e;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'b00,
        FR_START = 2'b01,
        FR_LOW   = 2'b10,
        FR_HIGH  = 2'b11
    } frame_e;
endpackage

// File: rtl/bwd_sync.sv
// Multi-stage synchroniser for a vector of asynchronous wires.
// Assumes: each bit is independent; the reset value models an idle bus.
module bwd_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            // First stage: capture the raw wire levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            // Later stages: shift toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bwd_frame_det.sv
// Detects start/stop conditions and tracks a qualifying frame:
// start, SCL low, SCL high, stop. Emits a one-cycle kick on that stop.
// Assumes: scl_s/sda_s are already synchronised to clk.
module bwd_frame_det
    import bwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic kick_o
);
    logic   scl_d, sda_d;
    logic   start_c, stop_c, scl_fall, scl_rise;
    frame_e st_q, st_n;

    // Delay the synchronised samples by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Bus conditions: SDA edges with SCL high in both samples.
    always_comb begin
        start_c  = scl_s && scl_d && sda_d && !sda_s;
        stop_c   = scl_s && scl_d && !sda_d && sda_s;
        scl_fall = scl_d && !scl_s;
        scl_rise = !scl_d && scl_s;
    end

    // Frame tracker next-state logic; start and stop override any phase.
    always_comb begin
        st_n = st_q;
        if (start_c) st_n = FR_START;
        else if (stop_c) st_n = FR_IDLE;
        else begin
            case (st_q)
                FR_START: if (scl_fall) st_n = FR_LOW;
                FR_LOW:   if (scl_rise) st_n = FR_HIGH;
                FR_HIGH:  if (scl_fall) st_n = FR_LOW;
                default:  st_n = st_q;
            endcase
        end
    end

    // Frame tracker state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_n;
    end

    assign kick_o = stop_c && (st_q == FR_HIGH);
endmodule

// File: rtl/bwd_timer.sv
// Timeout counter with period decode, restart on kick, expiry pulse.
// Assumes: all tick counts are >= 2 and TICKS_LONG is the largest.
module bwd_timer
    import bwd_pkg::*;
#(
    parameter int TICKS_LONG  = 4096,
    parameter int TICKS_MED   = 1024,
    parameter int TICKS_SHORT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  per_e per_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int CW = $clog2(TICKS_LONG + 1);

    logic [CW-1:0] cnt_q, lim_m1;
    logic          run;

    // Decode the selected limit (minus one) and the enable.
    always_comb begin
        run = 1'b1;
        case (per_i)
            PER_LONG:  lim_m1 = CW'(TICKS_LONG - 1);
            PER_MED:   lim_m1 = CW'(TICKS_MED - 1);
            PER_SHORT: lim_m1 = CW'(TICKS_SHORT - 1);
            default: begin
                lim_m1 = '0;
                run    = 1'b0;
            end
        endcase
    end

    // Count, restart on kick or disable, pulse and reload at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (kick_i || !run) begin
                cnt_q <= '0;
            end else if (cnt_q >= lim_m1) begin
                cnt_q    <= '0;
                expire_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_watchdog.sv
// Top: watchdog serviced by observed bus framing, with a lockable
// two-bit period register. Assumes scl_i/sda_i are asynchronous.
module bus_watchdog
    import bwd_pkg::*;
#(
    parameter int TICKS_LONG  = 4096,
    parameter int TICKS_MED   = 1024,
    parameter int TICKS_SHORT = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       wp_i,
    input  logic       per_we_i,
    input  logic [1:0] per_wdata_i,
    output logic [1:0] per_sel_o,
    output logic       timeout_o
);
    logic [1:0] bus_s;
    logic       kick;
    per_e       per_q;

    bwd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (bus_s)
    );

    bwd_frame_det u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (bus_s[1]),
        .sda_s  (bus_s[0]),
        .kick_o (kick)
    );

    // Period register: reset to the longest period, frozen by write protect.
    always_ff @(posedge clk) begin
        if (!rst_n)                  per_q <= PER_LONG;
        else if (per_we_i && !wp_i)  per_q <= per_e'(per_wdata_i);
    end

    bwd_timer #(
        .TICKS_LONG  (TICKS_LONG),
        .TICKS_MED   (TICKS_MED),
        .TICKS_SHORT (TICKS_SHORT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_i    (per_q),
        .kick_i   (kick),
        .expire_o (timeout_o)
    );

    assign per_sel_o = per_q;
endmodule

// File: rtl/bus_watchdog_chk.sv
// Assertion checker bound to bus_watchdog; observes ports only.
// Assumes: all tick counts are >= 2.
module bus_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_i,
    input logic       per_we_i,
    input logic [1:0] per_wdata_i,
    input logic [1:0] per_sel_o,
    input logic       timeout_o
);
    // R1: reset returns the period code to 00 and keeps the pulse low.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (per_sel_o == 2'b00 && !timeout_o));

    // R2: the expiry pulse lasts a single cycle.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    // R3: a disabled watchdog stays quiet.
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sel_o == 2'b11 && $past(per_sel_o) == 2'b11) |-> !timeout_o);

    // R4: an unlocked write lands on the next edge.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_we_i && !wp_i) |=> per_sel_o == $past(per_wdata_i));

    // R5: a locked write leaves the period unchanged.
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_we_i && wp_i) |=> $stable(per_sel_o));
endmodule

bind bus_watchdog bus_watchdog_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_i        (wp_i),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .per_sel_o   (per_sel_o),
    .timeout_o   (timeout_o)
);

// File: tb/bus_watchdog_tb.sv
// Self-checking bench: sweeps period codes, lock, and bus frame shapes.
module bus_watchdog_tb;
    localparam int CLK_P = 10;
    localparam int TL = 40;
    localparam int TM = 24;
    localparam int TS = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       wp = 1'b0;
    logic       we = 1'b0;
    logic [1:0] wd = 2'b00;
    logic [1:0] per;
    logic       to;

    int cyc = 0;
    int first_cyc = -1;
    int n_pulse = 0;
    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    bus_watchdog #(.TICKS_LONG(TL), .TICKS_MED(TM), .TICKS_SHORT(TS)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .wp_i(wp),
        .per_we_i(we), .per_wdata_i(wd), .per_sel_o(per), .timeout_o(to)
    );

    // Edge counter and pulse monitor, sampled a quarter period after the edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #(CLK_P/4);
        if (to) begin
            n_pulse = n_pulse + 1;
            if (first_cyc < 0) first_cyc = cyc;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mark();
        first_cyc = -1;
        n_pulse   = 0;
    endtask

    // Reset, then release while writing period p; c0 = release cycle.
    task automatic do_reset(input int p, output int c0);
        @(negedge clk);
        rst_n = 1'b0; scl = 1'b1; sda = 1'b1; we = 1'b0; wp = 1'b0;
        tick(3);
        rst_n = 1'b1; we = 1'b1; wd = 2'(p);
        c0 = cyc;
        mark();
        tick(1);
        we = 1'b0;
    endtask

    task automatic write_per(input bit lock, input int d);
        wp = lock; we = 1'b1; wd = 2'(d);
        tick(1);
        we = 1'b0; wp = 1'b0;
        tick(1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    function automatic int lim_of(input int p);
        return (p == 0) ? TL : (p == 1) ? TM : TS;
    endfunction

    initial begin
        #(CLK_P * 150000);
        tests++; fails++;
        $display("FAIL watchdog: run hung at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        int c0, c1, w;
        byte dat;

        // R1: state held in reset
        tick(2);
        check(per == 2'b00, "R1", "per_sel in reset", int'(per), 0);
        check(to == 1'b0, "R1", "timeout in reset", int'(to), 0);

        // R2: free-running pulses for each enabled code
        for (int p = 0; p < 3; p++) begin
            do_reset(p, c0);
            wait_until(c0 + 2*lim_of(p) + 1);
            check(per == 2'(p), "R4", "per_sel after write", int'(per), p);
            check(first_cyc == c0 + lim_of(p), "R2", "first pulse cycle",
                  first_cyc, c0 + lim_of(p));
            check(n_pulse == 2, "R2", "pulse count", n_pulse, 2);
        end

        // R3: disabled code
        do_reset(3, c0);
        wait_until(c0 + 3*TL);
        check(n_pulse == 0, "R3", "pulses while disabled", n_pulse, 0);

        // R4 / R5: exhaustive unlocked and locked writes
        do_reset(0, c0);
        for (int d = 0; d < 4; d++) begin
            write_per(1'b0, d);
            check(per == 2'(d), "R4", "unlocked write", int'(per), d);
        end
        write_per(1'b0, 2);
        for (int d = 0; d < 4; d++) begin
            write_per(1'b1, d);
            check(per == 2'b10, "R5", "locked write ignored", int'(per), 2);
        end

        // R6: minimal frame with two-cycle phases
        do_reset(1, c0);
        wait_until(c0 + 5);
        sda = 1'b0; tick(2);
        scl = 1'b0; tick(2);
        scl = 1'b1; tick(2);
        sda = 1'b1; c1 = cyc;
        mark();
        wait_until(c1 + 3 + TM + 1);
        check(first_cyc == c1 + 3 + TM, "R6", "pulse after minimal frame",
              first_cyc, c1 + 3 + TM);

        // R7: frame without stop
        do_reset(1, c0);
        wait_until(c0 + 5);
        sda = 1'b0; tick(2);
        scl = 1'b0; tick(2);
        scl = 1'b1; tick(2);
        wait_until(c0 + TM + 1);
        check(first_cyc == c0 + TM, "R7", "no restart without stop",
              first_cyc, c0 + TM);

        // R8: start directly followed by stop
        do_reset(1, c0);
        wait_until(c0 + 5);
        sda = 1'b0; tick(2);
        sda = 1'b1; tick(2);
        wait_until(c0 + TM + 1);
        check(first_cyc == c0 + TM, "R8", "no restart on bare start/stop",
              first_cyc, c0 + TM);

        // R9: full nine-bit transfer
        do_reset(0, c0);
        dat = 8'hA5;
        sda = 1'b0; tick(2);
        for (int b = 0; b < 9; b++) begin
            scl = 1'b0; tick(1);
            sda = (b < 8) ? dat[7-b] : 1'b0; tick(1);
            scl = 1'b1; tick(2);
        end
        scl = 1'b0; tick(1);
        sda = 1'b0; tick(1);
        scl = 1'b1; tick(2);
        sda = 1'b1; c1 = cyc;
        mark();
        wait_until(c1 + 3 + TL + 1);
        check(first_cyc == c1 + 3 + TL, "R9", "pulse after full transfer",
              first_cyc, c1 + 3 + TL);

        // R10: reset mid-count
        do_reset(0, c0);
        wait_until(c0 + 20);
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; c1 = cyc;
        wait_until(c1 + TL + 1);
        check(first_cyc == c1 + TL, "R10", "pulse after mid-count reset",
              first_cyc, c1 + TL);

        // R11: shrink period below current count
        do_reset(0, c0);
        wait_until(c0 + 30);
        we = 1'b1; wd = 2'b10; w = cyc;
        tick(1);
        we = 1'b0;
        wait_until(w + 3);
        check(first_cyc == w + 2, "R11", "immediate expiry after shrink",
              first_cyc, w + 2);

        summary();
        $finish;
    end
endmodule